// File: doc/BRIEF.md
# Software-Refilled Paging Translation Buffer

This block turns a segment:offset pair from user code into a 24-bit physical address. The pair becomes a linear virtual address, and an eight-slot, fully associative buffer translates it in 4 KB pages. Each slot holds three fields: a virtual page tag, a physical frame number and a permission mode. An access is translated only when it matches a slot's tag and the slot's mode allows that kind of access. Hardware never walks a page table. On a miss or a permission mismatch, the block latches a fault word and falls back to physical addressing. Software then resolves the fault and hands back a frame and a mode. The block writes these into the slot chosen by a rotating head pointer.

Translation runs only while the paging enable and the user-mode control are both high. In every other state the linear address goes out unchanged, which gives kernel code plain physical addressing. An indexed slot port lets software read any slot, or overwrite it, for example to invalidate one mapping. Turning paging off and back on clears every slot.

Top module: `soft_tlb`

## Requirements
- R1: With `compat_i`=0 the linear address is `(seg_i << 8) + off_i`, taken modulo 2^24.
- R2: With `compat_i`=1 the linear address is `(seg_i << 4) + off_i`, taken modulo 2^20 and zero-extended to 24 bits.
- R3: When `mmu_en_i`=0, `user_i`=0, or a fault is pending, an access passes through: `pa_o` equals the linear address and `xlate_ok_o`=1 in the same cycle.
- R4: When translation is active and a slot permits the access, `pa_o` is {slot frame, linear address bits 11:0} and `xlate_ok_o`=1 in the same cycle. The tag is linear address bits 23:12.
- R5: Access kinds are encoded 1 = fetch, 2 = read, 3 = write (0 is never permitted). Modes are encoded 0 = none, 1 = code, 2 = read-only, 3 = read-write. A fetch is permitted only by code, a read by read-only or read-write, and a write only by read-write. Mode none permits nothing.
- R6: When several slots match and permit an access, the lowest-numbered one supplies the frame.
- R7: An active access with no permitting slot drives `xlate_ok_o`=0 in the same cycle. From the next cycle `fault_o`=1, and `fault_word_o` = {2'b00, access kind in bits 13:12, tag in bits 11:0}.
- R8: While `fault_o` is high and `fault_ret_i` is low, `fault_o` stays high and `fault_word_o` holds its value, even when further accesses arrive.
- R9: A `fault_ret_i` pulse while a fault is pending writes {`ret_mode_i`, latched tag, `ret_frame_i`} into the slot at the head pointer. It then advances the head by one, modulo 8, and clears `fault_o` on the next cycle. A pulse with no fault pending changes nothing.
- R10: `slot_rdata_o` shows slot `slot_idx_i` combinationally, packed as mode in bits 25:24, tag in bits 23:12 and frame in bits 11:0. `slot_wr_i` loads `slot_wdata_i` into that slot at the clock edge.
- R11: After reset all slots read zero, the head is 0 and `fault_o`=0.
- R12: A rising edge on `mmu_en_i` zeroes every slot at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmu_en_i | input | 1 | Paging enable |
| user_i | input | 1 | User mode (translation requested) |
| compat_i | input | 1 | Select 4-bit segment shift (1 MB space) |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_kind_i | input | 2 | Access kind: 1 fetch, 2 read, 3 write |
| seg_i | input | 16 | Segment value |
| off_i | input | 16 | Offset |
| pa_o | output | 24 | Physical address |
| xlate_ok_o | output | 1 | Access permitted this cycle |
| fault_o | output | 1 | Fault pending |
| fault_word_o | output | 16 | Latched kind and tag |
| fault_ret_i | input | 1 | Fault-return strobe |
| ret_frame_i | input | 12 | Frame supplied by the handler |
| ret_mode_i | input | 2 | Mode supplied by the handler |
| slot_idx_i | input | 3 | Slot index for the register port |
| slot_wr_i | input | 1 | Slot write strobe |
| slot_wdata_i | input | 26 | Slot write data |
| slot_rdata_o | output | 26 | Slot read data |

## Verification
The hardest state to reach is a head pointer that has wrapped past slot 7. The only way to move the head from the ports is a complete fault/return round trip. The stimulus therefore runs a chain of deliberate misses, answers each one with a distinct frame, and reads slot 0 back to confirm that the last fill landed there. A stray return pulse with no fault pending must leave the head where it was. This shows up only later, when the next real fill lands in the expected slot. Mode-none slots are probed with all three access kinds inside a single low clock phase, so the permission check is seen without starting a fault.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
  localparam int TAG_W   = 12;
  localparam int FRAME_W = 12;
  localparam int PGOFF_W = 12;
  localparam int VA_W    = TAG_W + PGOFF_W;
  localparam int ENTRY_W = 2 + TAG_W + FRAME_W;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_CODE   = 2'd1,
    MODE_RDONLY = 2'd2,
    MODE_RDWR   = 2'd3
  } mode_e;

  typedef struct packed {
    mode_e              mode;
    logic [TAG_W-1:0]   tag;
    logic [FRAME_W-1:0] frame;
  } entry_t;

  // kind: 1 fetch, 2 read, 3 write, 0 never allowed
  function automatic logic mode_permits(mode_e m, logic [1:0] kind);
    case (kind)
      2'd1:    return (m == MODE_CODE);
      2'd2:    return (m == MODE_RDONLY) || (m == MODE_RDWR);
      2'd3:    return (m == MODE_RDWR);
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/soft_tlb_addr.sv
module soft_tlb_addr #(
  parameter int SEG_W      = 16,
  parameter int VA_W       = 24,
  parameter int WIDE_SHIFT = 8,
  parameter int COMPAT_SH  = 4,
  parameter int COMPAT_W   = 20
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [SEG_W-1:0] off_i,
  input  logic             compat_i,
  output logic [VA_W-1:0]  va_o
);
  logic [VA_W-1:0]     wide_seg, wide_off, wide_sum;
  logic [COMPAT_W-1:0] nar_seg, nar_off, nar_sum;

  always_comb begin
    wide_seg = VA_W'(seg_i);
    wide_off = VA_W'(off_i);
    wide_sum = (wide_seg << WIDE_SHIFT) + wide_off;
    nar_seg  = COMPAT_W'(seg_i);
    nar_off  = COMPAT_W'(off_i);
    nar_sum  = (nar_seg << COMPAT_SH) + nar_off;
    if (compat_i) va_o = {{(VA_W-COMPAT_W){1'b0}}, nar_sum};
    else          va_o = wide_sum;
  end
endmodule

// File: rtl/soft_tlb_cam.sv
module soft_tlb_cam
  import soft_tlb_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               fill_i,
  input  logic [IDX_W-1:0]   fill_idx_i,
  input  entry_t             fill_entry_i,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  entry_t             wdata_i,
  input  logic [TAG_W-1:0]   tag_i,
  input  logic [1:0]         kind_i,
  output logic               hit_o,
  output logic [FRAME_W-1:0] frame_o,
  output entry_t             rdata_o
);
  entry_t                 slot_q [NUM_SLOTS];
  entry_t                 slot_d [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]   match;
  logic [IDX_W-1:0]       sel;

  // next-state: flush beats fill, fill beats register-port write
  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      slot_d[i] = slot_q[i];
      if (flush_i)
        slot_d[i] = '0;
      else if (fill_i && (fill_idx_i == IDX_W'(i)))
        slot_d[i] = fill_entry_i;
      else if (wr_i && (idx_i == IDX_W'(i)))
        slot_d[i] = wdata_i;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else        slot_q[g] <= slot_d[g];
    end
    assign match[g] = (slot_q[g].tag == tag_i) && mode_permits(slot_q[g].mode, kind_i);
  end

  // lowest index wins: scan downward so lower indices overwrite
  always_comb begin
    hit_o = 1'b0;
    sel   = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  assign frame_o = slot_q[sel].frame;
  assign rdata_o = slot_q[idx_i];
endmodule

// File: rtl/soft_tlb_ctrl.sv
module soft_tlb_ctrl
  import soft_tlb_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mmu_en_i,
  input  logic             user_i,
  input  logic             acc_valid_i,
  input  logic [1:0]       acc_kind_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             hit_i,
  input  logic             fault_ret_i,
  output logic             active_o,
  output logic             flush_o,
  output logic             fill_o,
  output logic [IDX_W-1:0] head_o,
  output logic             fault_o,
  output logic [15:0]      fault_word_o
);
  logic             en_q;
  logic             fault_q, fault_d;
  logic [15:0]      word_q, word_d;
  logic             word_ce;
  logic [IDX_W-1:0] head_q, head_d;
  logic             raise;

  assign flush_o  = mmu_en_i & ~en_q;
  assign active_o = mmu_en_i & user_i & ~fault_q;
  assign raise    = acc_valid_i & active_o & ~hit_i;
  assign fill_o   = fault_ret_i & fault_q;

  always_comb begin
    fault_d = fault_q;
    word_ce = 1'b0;
    word_d  = word_q;
    head_d  = head_q;
    if (fill_o) begin
      fault_d = 1'b0;
      head_d  = (head_q == IDX_W'(NUM_SLOTS - 1)) ? '0 : head_q + 1'b1;
    end else if (raise) begin
      fault_d = 1'b1;
      word_ce = 1'b1;
      word_d  = {2'b00, acc_kind_i, tag_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      fault_q <= 1'b0;
      head_q  <= '0;
      word_q  <= '0;
    end else begin
      en_q    <= mmu_en_i;
      fault_q <= fault_d;
      head_q  <= head_d;
      if (word_ce) word_q <= word_d;
    end
  end

  assign head_o       = head_q;
  assign fault_o      = fault_q;
  assign fault_word_o = word_q;
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SEG_W     = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mmu_en_i,
  input  logic                  user_i,
  input  logic                  compat_i,
  input  logic                  acc_valid_i,
  input  logic [1:0]            acc_kind_i,
  input  logic [SEG_W-1:0]      seg_i,
  input  logic [SEG_W-1:0]      off_i,
  output logic [VA_W-1:0]       pa_o,
  output logic                  xlate_ok_o,
  output logic                  fault_o,
  output logic [15:0]           fault_word_o,
  input  logic                  fault_ret_i,
  input  logic [FRAME_W-1:0]    ret_frame_i,
  input  logic [1:0]            ret_mode_i,
  input  logic [IDX_W-1:0]      slot_idx_i,
  input  logic                  slot_wr_i,
  input  logic [ENTRY_W-1:0]    slot_wdata_i,
  output logic [ENTRY_W-1:0]    slot_rdata_o
);
  logic [VA_W-1:0]    va;
  logic               hit, active, flush, fill;
  logic [FRAME_W-1:0] hit_frame;
  logic [IDX_W-1:0]   head_q;
  entry_t             fill_entry, rd_entry;

  soft_tlb_addr #(.SEG_W(SEG_W), .VA_W(VA_W)) u_addr (
    .seg_i(seg_i), .off_i(off_i), .compat_i(compat_i), .va_o(va)
  );

  assign fill_entry = '{mode: mode_e'(ret_mode_i),
                        tag: fault_word_o[TAG_W-1:0],
                        frame: ret_frame_i};

  soft_tlb_cam #(.NUM_SLOTS(NUM_SLOTS)) u_cam (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .fill_i(fill), .fill_idx_i(head_q), .fill_entry_i(fill_entry),
    .wr_i(slot_wr_i), .idx_i(slot_idx_i), .wdata_i(entry_t'(slot_wdata_i)),
    .tag_i(va[VA_W-1:PGOFF_W]), .kind_i(acc_kind_i),
    .hit_o(hit), .frame_o(hit_frame), .rdata_o(rd_entry)
  );

  soft_tlb_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mmu_en_i(mmu_en_i), .user_i(user_i),
    .acc_valid_i(acc_valid_i), .acc_kind_i(acc_kind_i),
    .tag_i(va[VA_W-1:PGOFF_W]), .hit_i(hit), .fault_ret_i(fault_ret_i),
    .active_o(active), .flush_o(flush), .fill_o(fill), .head_o(head_q),
    .fault_o(fault_o), .fault_word_o(fault_word_o)
  );

  assign pa_o         = (active && hit) ? {hit_frame, va[PGOFF_W-1:0]} : va;
  assign xlate_ok_o   = acc_valid_i & (~active | hit);
  assign slot_rdata_o = rd_entry;
endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mmu_en_i,
  input logic             user_i,
  input logic             acc_valid_i,
  input logic             fault_ret_i,
  input logic             xlate_ok_o,
  input logic             fault_o,
  input logic [15:0]      fault_word_o,
  input logic [IDX_W-1:0] head
);
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && (!mmu_en_i || !user_i || fault_o)) |-> xlate_ok_o);

  assert_fault_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> $past(acc_valid_i && mmu_en_i && user_i && !xlate_ok_o));

  assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !fault_ret_i) |=> (fault_o && $stable(fault_word_o)));

  assert_fault_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && fault_ret_i) |=> !fault_o);

  assert_head_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && fault_ret_i) |=> (head != $past(head)));

  assert_head_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_o && fault_ret_i) |=> $stable(head));
endmodule

bind soft_tlb soft_tlb_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mmu_en_i(mmu_en_i), .user_i(user_i),
  .acc_valid_i(acc_valid_i), .fault_ret_i(fault_ret_i),
  .xlate_ok_o(xlate_ok_o), .fault_o(fault_o), .fault_word_o(fault_word_o),
  .head(head_q)
);

// File: tb/soft_tlb_bench.sv
`timescale 1ns/1ps
module soft_tlb_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mmu_en, user, compat, acc_valid, fault_ret, slot_wr;
  logic [1:0]  acc_kind, ret_mode;
  logic [15:0] seg, off, fault_word;
  logic [23:0] pa;
  logic        ok, fault;
  logic [11:0] ret_frame;
  logic [2:0]  slot_idx;
  logic [25:0] slot_wdata, slot_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  soft_tlb u_soft_tlb (
    .clk(clk), .rst_n(rst_n), .mmu_en_i(mmu_en), .user_i(user), .compat_i(compat),
    .acc_valid_i(acc_valid), .acc_kind_i(acc_kind), .seg_i(seg), .off_i(off),
    .pa_o(pa), .xlate_ok_o(ok), .fault_o(fault), .fault_word_o(fault_word),
    .fault_ret_i(fault_ret), .ret_frame_i(ret_frame), .ret_mode_i(ret_mode),
    .slot_idx_i(slot_idx), .slot_wr_i(slot_wr), .slot_wdata_i(slot_wdata),
    .slot_rdata_o(slot_rdata)
  );

  typedef struct packed {
    logic        mmu, usr, cmp;
    logic [1:0]  kind;
    logic [15:0] s, o;
    logic [23:0] exp_pa;
  } vec_t;

  localparam vec_t VEC [12] = '{
    {1'b1,1'b1,1'b0,2'd1,16'h0120,16'h0ABC,24'hA01ABC}, // R4 R1 fetch code slot
    {1'b1,1'b1,1'b0,2'd1,16'h0110,16'h1FFF,24'hA01FFF}, // R1 offset carries into tag
    {1'b1,1'b1,1'b0,2'd2,16'h3450,16'h0123,24'hB02123}, // R5 read of read-only
    {1'b1,1'b1,1'b0,2'd2,16'h6780,16'h0004,24'hC03004}, // R6 slots 2,3 match, 2 wins
    {1'b1,1'b1,1'b0,2'd3,16'h6780,16'h0FFC,24'hC03FFC}, // R6 write, slot 2 wins
    {1'b1,1'b1,1'b0,2'd2,16'h9AB0,16'h0010,24'hE05010}, // R5 read takes read-only slot 4
    {1'b1,1'b1,1'b0,2'd3,16'h9AB0,16'h0010,24'hF06010}, // R5 write skips slot 4, uses 5
    {1'b1,1'b1,1'b1,2'd1,16'h1200,16'h0034,24'hA01034}, // R2 compat form then translate
    {1'b1,1'b0,1'b0,2'd1,16'hFFFF,16'hFFFF,24'h00FEFF}, // R3 kernel bypass, R1 wrap 2^24
    {1'b0,1'b1,1'b0,2'd3,16'h1234,16'h5678,24'h128A78}, // R3 paging off
    {1'b0,1'b1,1'b1,2'd2,16'hFFFF,16'h0010,24'h000000}, // R2 wraps at 1 MB
    {1'b0,1'b1,1'b1,2'd2,16'h1234,16'h0005,24'h012345}  // R2
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic slot_write(int idx, logic [25:0] d);
    @(negedge clk);
    slot_idx = 3'(idx); slot_wdata = d; slot_wr = 1'b1;
    @(negedge clk);
    slot_wr = 1'b0;
  endtask

  task automatic slot_check(string req, int idx, logic [25:0] exp);
    slot_idx = 3'(idx);
    #0.5;
    check(req, 32'(slot_rdata), 32'(exp));
  endtask

  task automatic preload();
    slot_write(0, 26'h1012A01);
    slot_write(1, 26'h2345B02);
    slot_write(2, 26'h3678C03);
    slot_write(3, 26'h3678D04);
    slot_write(4, 26'h29ABE05);
    slot_write(5, 26'h39ABF06);
    slot_write(6, 26'h0000000);
    slot_write(7, 26'h0000000);
  endtask

  // access driven at a negedge, left on for one posedge
  task automatic access(logic [1:0] k, logic [15:0] s, logic [15:0] o);
    @(negedge clk);
    acc_kind = k; seg = s; off = o; acc_valid = 1'b1;
    #1;
  endtask

  task automatic handler_return(logic [11:0] f, logic [1:0] m);
    @(negedge clk);
    acc_valid = 1'b0;
    fault_ret = 1'b1; ret_frame = f; ret_mode = m;
    @(negedge clk);
    fault_ret = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mmu_en = 0; user = 0; compat = 0; acc_valid = 0; acc_kind = 0;
    seg = 0; off = 0; fault_ret = 0; ret_frame = 0; ret_mode = 0;
    slot_idx = 0; slot_wr = 0; slot_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    check("R11 fault after reset", 32'(fault), 0);
    slot_check("R11 slot 5 after reset", 5, 26'h0);

    @(negedge clk);
    mmu_en = 1; user = 1;
    @(negedge clk);
    preload();
    slot_check("R10 slot read", 3, 26'h3678D04);

    // table walk
    foreach (VEC[i]) begin
      @(negedge clk);
      mmu_en = VEC[i].mmu; user = VEC[i].usr; compat = VEC[i].cmp;
      acc_kind = VEC[i].kind; seg = VEC[i].s; off = VEC[i].o; acc_valid = 1;
      #1;
      check($sformatf("R4 vector %0d pa", i), 32'(pa), 32'(VEC[i].exp_pa));
      check($sformatf("R5 vector %0d ok", i), 32'(ok), 1);
    end
    @(negedge clk);
    acc_valid = 0; compat = 0;
    #1;
    check("R5 no fault from table", 32'(fault), 0);

    // R12: re-enable flushes
    mmu_en = 1; user = 1;
    @(negedge clk);
    #1;
    slot_check("R12 slot 2 flushed", 2, 26'h0);
    acc_kind = 2'd2; seg = 16'h6780; off = 0; acc_valid = 1;
    #0.5;
    check("R12 no match after flush", 32'(ok), 0);
    acc_valid = 0;
    preload();

    // R7 miss fault
    access(2'd1, 16'h0130, 16'h0555);
    check("R7 miss not ok", 32'(ok), 0);
    @(negedge clk);
    acc_valid = 0;
    #1;
    check("R7 fault raised", 32'(fault), 1);
    check("R7 fault word", 32'(fault_word), 32'h1013);
    access(2'd1, 16'h0130, 16'h0555);
    check("R3 pending bypass pa", 32'(pa), 32'h013555);
    check("R3 pending bypass ok", 32'(ok), 1);
    access(2'd2, 16'h0EE0, 16'h0000);
    @(negedge clk);
    acc_valid = 0;
    #1;
    check("R8 word held", 32'(fault_word), 32'h1013);
    check("R8 fault held", 32'(fault), 1);
    handler_return(12'h777, 2'd1);
    check("R9 fault cleared", 32'(fault), 0);
    slot_check("R9 fill into head 0", 0, 26'h1013777);
    access(2'd1, 16'h0130, 16'h0555);
    check("R9 refilled translate", 32'(pa), 32'h777555);

    // R7 permission mismatch: write to read-only slot 1
    access(2'd3, 16'h3450, 16'h0020);
    check("R7 mismatch not ok", 32'(ok), 0);
    @(negedge clk);
    acc_valid = 0;
    #1;
    check("R7 mismatch word", 32'(fault_word), 32'h3345);
    handler_return(12'hB02, 2'd3);
    slot_check("R9 fill into head 1", 1, 26'h3345B02);
    access(2'd3, 16'h3450, 16'h0020);
    check("R9 write now ok", 32'(pa), 32'hB02020);

    // R9 stray return has no effect
    handler_return(12'hFFF, 2'd3);
    check("R9 stray return no fault", 32'(fault), 0);
    slot_check("R9 stray return slot 2", 2, 26'h3678C03);
    access(2'd2, 16'h0550, 16'h0000);
    @(negedge clk);
    acc_valid = 0;
    #1;
    check("R7 fault word read", 32'(fault_word), 32'h2055);
    handler_return(12'h055, 2'd2);
    slot_check("R9 head not moved by stray", 2, 26'h2055055);
    slot_check("R9 slot 3 untouched", 3, 26'h3678D04);

    // R9 head wrap: slots 3..7 then 0
    for (int k = 0; k < 6; k++) begin
      access(2'd3, 16'(16'h1000 + k * 16), 16'h0000);
      @(negedge clk);
      acc_valid = 0;
      handler_return(12'(12'h200 + k), 2'd3);
    end
    slot_check("R9 wrap slot 7", 7, 26'h3104204);
    slot_check("R9 wrap slot 0", 0, 26'h3105205);

    // R5 mode none permits nothing
    slot_write(6, 26'h00AA111);
    @(negedge clk);
    seg = 16'h0AA0; off = 0; acc_valid = 1; acc_kind = 2'd1;
    #0.4; check("R5 none fetch", 32'(ok), 0);
    acc_kind = 2'd2;
    #0.4; check("R5 none read", 32'(ok), 0);
    acc_kind = 2'd3;
    #0.4; check("R5 none write", 32'(ok), 0);
    acc_valid = 0;
    @(negedge clk);
    #1;
    check("R5 none probe raised no fault", 32'(fault), 0);

    // R10 invalidate one slot
    slot_write(4, 26'h0);
    slot_check("R10 slot 4 cleared", 4, 26'h0);
    slot_check("R10 slot 5 kept", 5, 26'h3102202);

    finish_run();
  end
endmodule